// File: doc/BRIEF.md
# Run-Time Selectable Maximal-Length Sequence Generator

This block produces a pseudo-random bit stream from a Fibonacci linear feedback shift register whose active length runs from 2 to 12 stages. Stage 1 takes the exclusive-OR of a fixed tap set, and each other stage takes the previous value of the stage below it. Every length has its own tap set, so the register passes through all nonzero patterns of that length before it returns to its starting point.

The length select is sampled once. This happens on the first rising clock edge after the reset is released. After that the length stays fixed until the next reset, so a change on the select pins can never corrupt a running sequence. The full register is visible, and only its low r bits can be nonzero. The highest active stage drives the serial output. A flag is high while the register holds the seed, and it marks one cycle of every period.

Top module: `seqgen_top`

## Requirements
- R1: While rst_n is low, state_o equals 12'h001 (stage 1 set, all other stages clear), and ser_o and period_o are 0.
- R2: The length is captured from len_sel on the third rising clock edge after rst_n rises, and state_o does not move on that edge. After capture, changes on len_sel have no effect until the next reset.
- R3: On each rising edge after capture with en high, stage k+1 takes the old value of stage k. Stage 1 takes the XOR of the old values of the tap stages. Stage k is state_o bit k-1, and the tap stages by length are: 2:{2,1} 3:{3,1} 4:{4,1} 5:{5,2} 6:{6,1} 7:{7,1} 8:{8,5,3,1} 9:{9,4} 10:{10,3} 11:{11,2} 12:{12,6,4,1}.
- R4: For every length r, starting from the seed, the register visits exactly 2^r-1 distinct nonzero states, and the seed returns after 2^r-1 enabled edges.
- R5: Bits of state_o at positions r and above are always 0.
- R6: While en is low, state_o holds its value.
- R7: ser_o equals stage r, which is state_o bit r-1.
- R8: After capture, period_o is 1 exactly when state_o equals the seed 12'h001. Before capture it is 0.
- R9: A len_sel value outside 2..12 (0, 1, 13, 14, 15) selects length 12.
- R10: Driving rst_n low returns state_o to the seed and period_o to 0 without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and releases through a two-stage synchronizer |
| en | input | 1 | Advance enable |
| len_sel | input | 4 | Requested register length, sampled once after reset |
| state_o | output | 12 | Register contents, where bit k-1 is stage k |
| ser_o | output | 1 | Serial output taken from the highest active stage |
| period_o | output | 1 | High while the register holds the seed |

## Verification
The bench sweeps every length from 2 to 12 through a whole period. It compares each step against a reference register built from the tap lists, and it keeps a visited map to prove that no state repeats before the seed returns. This check catches a wrong tap set at any length: a wrong set gives a short cycle, so the seed comes back early or a state repeats. It also catches a mask that lets a high stage leak, because that breaks the upper-zero check. Out-of-range selects are run through the full 4095-state period, which exposes a decoder that wraps them to a short length. The select is changed right after capture, so a design that keeps tracking len_sel would drift off the reference. A mid-run stall and a mid-cycle reset catch enable leakage and a reset that waits for a clock edge.

// File: rtl/seqgen_pkg.sv
`timescale 1ns/1ps
package seqgen_pkg;
  localparam int unsigned STAGES_MAX = 12;
  localparam int unsigned LEN_W      = 4;
  localparam int unsigned LEN_MIN    = 2;
  localparam logic [STAGES_MAX-1:0] SEED = STAGES_MAX'(1);

  typedef logic [STAGES_MAX-1:0] stage_vec_t;
  typedef logic [LEN_W-1:0]      len_t;

  // Feedback mask per length; bit k-1 set means stage k feeds stage 1.
  function automatic stage_vec_t tap_mask(input len_t len);
    stage_vec_t m;
    case (len)
      4'd2:    m = 12'h003;
      4'd3:    m = 12'h005;
      4'd4:    m = 12'h009;
      4'd5:    m = 12'h012;
      4'd6:    m = 12'h021;
      4'd7:    m = 12'h041;
      4'd8:    m = 12'h095;
      4'd9:    m = 12'h108;
      4'd10:   m = 12'h204;
      4'd11:   m = 12'h402;
      default: m = 12'h829;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/seqgen_rst_sync.sv
`timescale 1ns/1ps
module seqgen_rst_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [DEPTH-1:0] sync_q;
  logic [DEPTH-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_ni = sync_q[DEPTH-1];
endmodule

// File: rtl/seqgen_len_ctl.sv
`timescale 1ns/1ps
module seqgen_len_ctl
  import seqgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  len_t       len_sel,
  output logic       armed_o,
  output stage_vec_t len_mask_o,
  output stage_vec_t top_stage_o,
  output stage_vec_t fb_mask_o
);
  localparam len_t LEN_MAX_V = len_t'(STAGES_MAX);
  localparam len_t LEN_MIN_V = len_t'(LEN_MIN);

  len_t len_q, len_d;
  logic armed_q, armed_d;
  logic sel_legal;

  always_comb begin
    sel_legal = (len_sel >= LEN_MIN_V) && (len_sel <= LEN_MAX_V);
    len_d     = sel_legal ? len_sel : LEN_MAX_V;
    armed_d   = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q   <= LEN_MAX_V;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      len_q   <= len_d;
      armed_q <= armed_d;
    end
  end

  for (genvar g = 0; g < STAGES_MAX; g++) begin : g_stage_dec
    assign len_mask_o[g]  = (len_q > len_t'(g));
    assign top_stage_o[g] = (len_q == len_t'(g + 1));
  end

  assign fb_mask_o = tap_mask(len_q);
  assign armed_o   = armed_q;

  // R2: captured length never moves once armed
  a_r2_len_frozen: assert property (@(posedge clk) disable iff (!rst_ni)
    armed_q |=> $stable(len_q));
  // R9: captured length always lies in the legal range
  a_r9_len_legal: assert property (@(posedge clk) disable iff (!rst_ni)
    armed_q |-> (len_q >= LEN_MIN_V && len_q <= LEN_MAX_V));
  // R7: exactly one stage is marked as the serial source
  a_r7_one_top: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(top_stage_o) && (top_stage_o != '0));
endmodule

// File: rtl/seqgen_shift.sv
`timescale 1ns/1ps
module seqgen_shift
  import seqgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       step_i,
  input  stage_vec_t fb_mask_i,
  input  stage_vec_t len_mask_i,
  output stage_vec_t state_o
);
  stage_vec_t state_q, state_d;
  logic       fb_bit;

  always_comb begin
    fb_bit  = ^(state_q & fb_mask_i);
    state_d = state_q;
    if (step_i) state_d = {state_q[STAGES_MAX-2:0], fb_bit} & len_mask_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign state_o = state_q;

  // R4: the lock-up pattern is never entered
  a_r4_never_zero: assert property (@(posedge clk) disable iff (!rst_ni)
    state_q != '0);
  // R5: stages beyond the active length stay clear
  a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q & ~len_mask_i) == '0);
  // R6: no step means no change
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !step_i |=> $stable(state_q));
  // R3: stage 2 takes the old stage 1
  a_r3_chain: assert property (@(posedge clk) disable iff (!rst_ni)
    step_i |=> state_q[1] == $past(state_q[0]));
endmodule

// File: rtl/seqgen_top.sv
`timescale 1ns/1ps
module seqgen_top
  import seqgen_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [3:0]  len_sel,
  output logic [11:0] state_o,
  output logic        ser_o,
  output logic        period_o
);
  logic       rst_ni;
  logic       armed;
  logic       step;
  stage_vec_t len_mask, top_stage, fb_mask, state;

  seqgen_rst_sync #(.DEPTH(2)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  seqgen_len_ctl u_len (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .len_sel     (len_sel),
    .armed_o     (armed),
    .len_mask_o  (len_mask),
    .top_stage_o (top_stage),
    .fb_mask_o   (fb_mask)
  );

  assign step = en & armed;

  seqgen_shift u_shift (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .step_i     (step),
    .fb_mask_i  (fb_mask),
    .len_mask_i (len_mask),
    .state_o    (state)
  );

  assign state_o  = state;
  assign ser_o    = |(state & top_stage);
  assign period_o = armed & (state == SEED);

  // R8: the period flag implies stage 1 set and every other stage clear
  a_r8_flag_seed: assert property (@(posedge clk) disable iff (!rst_ni)
    period_o |-> (state_o[0] && $countones(state_o) == 1));
endmodule

// File: tb/seqgen_top_tb_top.sv
`timescale 1ns/1ps
module seqgen_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, en;
  logic [3:0]  len_sel;
  logic [11:0] state_o;
  logic        ser_o, period_o;
  int checks = 0;
  int errors = 0;

  seqgen_top dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .len_sel(len_sel),
    .state_o(state_o), .ser_o(ser_o), .period_o(period_o)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [11:0] stg(input int k);
    return 12'(1) << (k - 1);
  endfunction

  function automatic logic [11:0] ref_taps(input int r);
    case (r)
      2:  return stg(2)  | stg(1);
      3:  return stg(3)  | stg(1);
      4:  return stg(4)  | stg(1);
      5:  return stg(5)  | stg(2);
      6:  return stg(6)  | stg(1);
      7:  return stg(7)  | stg(1);
      8:  return stg(8)  | stg(5) | stg(3) | stg(1);
      9:  return stg(9)  | stg(4);
      10: return stg(10) | stg(3);
      11: return stg(11) | stg(2);
      default: return stg(12) | stg(6) | stg(4) | stg(1);
    endcase
  endfunction

  function automatic logic [11:0] ref_next(input logic [11:0] s, input int r);
    logic fb;
    logic [11:0] msk;
    fb  = ^(s & ref_taps(r));
    msk = 12'((1 << r) - 1);
    return {s[10:0], fb} & msk;
  endfunction

  task automatic reset_capture(input logic [3:0] sel);
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; len_sel = sel;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_full(input logic [3:0] sel, input int r);
    logic [4095:0] vis;
    logic [11:0] exp_s;
    int steps, mism, dup, upper;
    longint first_act, first_exp;
    reset_capture(sel);
    chk(state_o == 12'h001 && period_o, "R2", "seed after capture", state_o, 12'h001);
    len_sel = ~sel;  // R2: must be ignored from here on
    en = 1'b1;
    vis = '0; exp_s = 12'h001; steps = 0; mism = 0; dup = 0; upper = 0;
    first_act = 0; first_exp = 0;
    for (int i = 0; i < 4200; i++) begin
      @(negedge clk);
      exp_s = ref_next(exp_s, r);
      steps++;
      if (state_o != exp_s || ser_o != exp_s[r-1] || period_o != (exp_s == 12'h001)
          || state_o == 12'h000) begin
        if (mism == 0) begin first_act = state_o; first_exp = exp_s; end
        mism++;
      end
      if ((state_o >> r) != 0) upper++;
      if (vis[state_o]) dup++;
      vis[state_o] = 1'b1;
      if (state_o == 12'h001) break;
    end
    en = 1'b0;
    chk(mism == 0, "R3/R7/R8", $sformatf("step match len %0d", r), first_act, first_exp);
    chk(steps == (1 << r) - 1, "R4", $sformatf("period len %0d sel %0d", r, sel),
        steps, (1 << r) - 1);
    chk(dup == 0, "R4", $sformatf("repeats len %0d", r), dup, 0);
    chk(upper == 0, "R5", $sformatf("upper bits len %0d", r), upper, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] held, exp_s;
    rst_n = 1'b0; en = 1'b0; len_sel = 4'd5;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(state_o == 12'h001, "R1", "reset state", state_o, 12'h001);
    chk(!ser_o && !period_o, "R1", "reset ser/period", {ser_o, period_o}, 0);

    for (int r = 2; r <= 12; r++) run_full(4'(r), r);
    // R9 out-of-range selects behave as length 12
    run_full(4'd0, 12);
    run_full(4'd13, 12);

    // R6 hold while en is low
    reset_capture(4'd5);
    en = 1'b1;
    repeat (3) @(negedge clk);
    en = 1'b0;
    held = state_o;
    exp_s = 12'h001;
    for (int i = 0; i < 3; i++) exp_s = ref_next(exp_s, 5);
    chk(held == exp_s, "R6", "pre-stall state", held, exp_s);
    repeat (4) @(negedge clk);
    chk(state_o == held, "R6", "stalled state", state_o, held);
    en = 1'b1;
    @(negedge clk);
    chk(state_o == ref_next(held, 5), "R6", "resume step", state_o, ref_next(held, 5));

    // R10 asynchronous reset mid-cycle
    reset_capture(4'd4);
    en = 1'b1;
    repeat (5) @(negedge clk);
    chk(state_o != 12'h001, "R10", "moved off seed", state_o, 0);
    #1 rst_n = 1'b0;
    #0.5;
    chk(state_o == 12'h001, "R10", "async seed", state_o, 12'h001);
    chk(!period_o, "R10", "flag cleared", period_o, 0);
    en = 1'b0;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule